// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns a decoded instruction's addressing information into an effective address. A one-cycle `start` pulse carries a mode code, a register selector, the address of the instruction's first byte, the instruction's byte length and its address field. The unit drives the selector straight to a register-file read port. It returns either a computed sum or, for the two indirect modes, a word read from memory through a request/valid port.

Offset modes add a register or the program counter to the field, with the sum wrapping at 16 bits. The program counter used for relative addressing is the one that would exist after every byte of the instruction has been fetched, which is the instruction address plus its length. The pre-indexed indirect mode first forms register plus field and then reads memory at that sum. Plain indirect reads memory at the field itself.

Each accepted operation ends with a single-cycle `done` strobe and the address on `ea`. An unknown mode code ends with a single-cycle `illegal` strobe instead.

Top module: `eag_unit`

## Requirements
- R1: Mode 3'b000 (PC-relative) gives ea = pc + ilen + sign-extended field[7:0], modulo 2^16. For example, pc 2000H, ilen 2 and field 06H give 2008H, and pc 0010H, ilen 2 and field F0H give 0002H.
- R2: Mode 3'b001 (indexed) gives ea = R[reg_sel] + field, modulo 2^16. The register value is read through rf_addr/rf_data, and rf_addr equals reg_sel.
- R3: Mode 3'b010 (base plus offset) treats field as a 16-bit two's-complement offset (-32768..+32767) and gives ea = R[reg_sel] + offset, wrapping modulo 2^16.
- R4: Mode 3'b011 (pre-indexed indirect) issues a memory read at R[reg_sel] + field. ea is the word returned on mem_rdata.
- R5: Mode 3'b100 (plain indirect) issues a memory read at field. ea is the returned word.
- R6: done is high for exactly one cycle per operation. For modes 000 to 010 it is high in the cycle after start. For indirect modes it is high in the cycle after mem_valid is sampled high.
- R7: Mode codes 101, 110 and 111 raise illegal for one cycle, in the cycle after start. done stays low, no memory request is made, and ea keeps its previous value.
- R8: mem_req rises in the cycle after an indirect start. It stays high with a stable mem_addr until mem_valid is seen, and it falls in the following cycle.
- R9: A start that arrives while busy is high (an indirect read is pending) is ignored: it produces no done, no illegal and no change to the pending result.
- R10: After reset, ea is 0 and done, illegal, mem_req and busy are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation request, one cycle |
| mode | input | 3 | Addressing mode code |
| reg_sel | input | 4 | Index/base register selector |
| pc | input | 16 | Address of the instruction's first byte |
| ilen | input | 2 | Instruction length in bytes |
| field | input | 16 | Address/displacement field |
| rf_addr | output | 4 | Register-file read address |
| rf_data | input | 16 | Register-file read data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_valid | input | 1 | Memory read data valid |
| mem_rdata | input | 16 | Memory read data |
| ea | output | 16 | Effective address |
| done | output | 1 | Result strobe |
| illegal | output | 1 | Unknown-mode strobe |
| busy | output | 1 | Indirect read pending |

## Verification
The bench drives relative branches whose displacement is negative, and others whose sum crosses FFFFH. A design that used the PC before the instruction was fetched would land short by the instruction length. A design that zero-extended the displacement would jump forward by 256 instead of backward. Indirect operations run with memory latencies from zero to three cycles. A design that dropped or moved its request too early, or that returned the intermediate sum instead of the fetched word, would be caught, and so would one that took the register plus field path for plain indirect. Unknown modes and starts issued while a read is pending are checked at the ports to confirm that `ea` is untouched and that no strobe appears.

// File: rtl/eag_pkg.sv
`timescale 1ns/1ps
package eag_pkg;
  typedef enum logic [2:0] {
    MODE_PCREL  = 3'b000,
    MODE_INDEX  = 3'b001,
    MODE_BASE   = 3'b010,
    MODE_PREIND = 3'b011,
    MODE_INDIR  = 3'b100
  } eag_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } eag_state_e;
endpackage

// File: rtl/eag_calc.sv
`timescale 1ns/1ps
module eag_calc #(
  parameter int AW     = 16,
  parameter int DISP_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic [2:0]       mode,
  input  logic [AW-1:0]    pc,
  input  logic [LEN_W-1:0] ilen,
  input  logic [AW-1:0]    field,
  input  logic [AW-1:0]    reg_val,
  output logic [AW-1:0]    direct_ea,
  output logic [AW-1:0]    ind_addr,
  output logic             is_direct,
  output logic             is_indirect,
  output logic             is_illegal
);
  import eag_pkg::*;

  localparam int EXT_W = AW - DISP_W;

  function automatic logic [AW-1:0] sext_disp(input logic [DISP_W-1:0] d);
    return {{EXT_W{d[DISP_W-1]}}, d};
  endfunction

  function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a + b;
  endfunction

  function automatic logic [AW-1:0] pc_after_fetch(input logic [AW-1:0] p, input logic [LEN_W-1:0] n);
    return p + AW'(n);
  endfunction

  logic [AW-1:0] rel_sum;
  logic [AW-1:0] reg_sum;

  assign rel_sum = wrap_add(pc_after_fetch(pc, ilen), sext_disp(field[DISP_W-1:0]));
  assign reg_sum = wrap_add(reg_val, field);

  always_comb begin
    direct_ea   = reg_sum;
    ind_addr    = field;
    is_direct   = 1'b0;
    is_indirect = 1'b0;
    is_illegal  = 1'b0;
    case (mode)
      MODE_PCREL: begin
        direct_ea = rel_sum;
        is_direct = 1'b1;
      end
      MODE_INDEX, MODE_BASE: begin
        is_direct = 1'b1;
      end
      MODE_PREIND: begin
        ind_addr    = reg_sum;
        is_indirect = 1'b1;
      end
      MODE_INDIR: begin
        is_indirect = 1'b1;
      end
      default: is_illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/eag_ctrl.sv
`timescale 1ns/1ps
module eag_ctrl #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_direct,
  input  logic          is_indirect,
  input  logic          is_illegal,
  input  logic [AW-1:0] direct_ea,
  input  logic [AW-1:0] ind_addr,
  input  logic          mem_valid,
  input  logic [AW-1:0] mem_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] ea,
  output logic          done,
  output logic          illegal,
  output logic          busy
);
  import eag_pkg::*;

  eag_state_e state;

  logic accept_start;
  logic take_direct;
  logic take_indirect;
  logic take_illegal;
  logic resp_take;

  assign accept_start  = start && (state == ST_IDLE);
  assign take_direct   = accept_start && is_direct;
  assign take_indirect = accept_start && is_indirect;
  assign take_illegal  = accept_start && is_illegal;
  assign resp_take     = (state == ST_WAIT) && mem_valid;
  assign busy          = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ea       <= '0;
      done     <= 1'b0;
      illegal  <= 1'b0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      if (take_direct) begin
        ea   <= direct_ea;
        done <= 1'b1;
      end else if (take_indirect) begin
        mem_req  <= 1'b1;
        mem_addr <= ind_addr;
        state    <= ST_WAIT;
      end else if (take_illegal) begin
        illegal <= 1'b1;
      end
      if (resp_take) begin
        ea      <= mem_rdata;
        done    <= 1'b1;
        mem_req <= 1'b0;
        state   <= ST_IDLE;
      end
    end
  end

  // R7: the mode decode yields exactly one class
  a_r7_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    accept_start |-> $onehot({is_direct, is_indirect, is_illegal}));

  // R6: a direct operation delivers its sum one cycle later
  a_r6_direct_latency: assert property (@(posedge clk) disable iff (!rst_n)
    take_direct |=> done && (ea == $past(direct_ea)));

  // R6: done only follows a direct take or a memory response
  a_r6_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(take_direct) || $past(resp_take)));

  // R7: illegal strobe is quiet on every other output
  a_r7_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!done && !mem_req && $stable(ea)));

  // R8: request held with a steady address until valid
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R8: request dropped and result delivered after valid
  a_r8_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid) |=> (!mem_req && done && (ea == $past(mem_rdata))));

  // R9: start during a pending read has no visible effect
  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !mem_valid) |=> (!done && !illegal && mem_req));
endmodule

// File: rtl/eag_unit.sv
`timescale 1ns/1ps
module eag_unit #(
  parameter int AW     = 16,
  parameter int DISP_W = 8,
  parameter int LEN_W  = 2,
  parameter int NREG   = 16,
  localparam int RSEL_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [RSEL_W-1:0] reg_sel,
  input  logic [AW-1:0]     pc,
  input  logic [LEN_W-1:0]  ilen,
  input  logic [AW-1:0]     field,
  output logic [RSEL_W-1:0] rf_addr,
  input  logic [AW-1:0]     rf_data,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_valid,
  input  logic [AW-1:0]     mem_rdata,
  output logic [AW-1:0]     ea,
  output logic              done,
  output logic              illegal,
  output logic              busy
);
  logic [AW-1:0] direct_ea;
  logic [AW-1:0] ind_addr;
  logic          is_direct;
  logic          is_indirect;
  logic          is_illegal;

  assign rf_addr = reg_sel;

  eag_calc #(.AW(AW), .DISP_W(DISP_W), .LEN_W(LEN_W)) u_calc (
    .mode        (mode),
    .pc          (pc),
    .ilen        (ilen),
    .field       (field),
    .reg_val     (rf_data),
    .direct_ea   (direct_ea),
    .ind_addr    (ind_addr),
    .is_direct   (is_direct),
    .is_indirect (is_indirect),
    .is_illegal  (is_illegal)
  );

  eag_ctrl #(.AW(AW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .is_direct   (is_direct),
    .is_indirect (is_indirect),
    .is_illegal  (is_illegal),
    .direct_ea   (direct_ea),
    .ind_addr    (ind_addr),
    .mem_valid   (mem_valid),
    .mem_rdata   (mem_rdata),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .ea          (ea),
    .done        (done),
    .illegal     (illegal),
    .busy        (busy)
  );

  // R10: outputs quiet during the first cycle after reset release
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!done && !illegal && !mem_req && !busy && (ea == '0)));
endmodule

// File: tb/eag_unit_test.sv
`timescale 1ns/1ps
module eag_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [3:0]  reg_sel = '0;
  logic [15:0] pc = '0;
  logic [1:0]  ilen = '0;
  logic [15:0] field = '0;
  logic [3:0]  rf_addr;
  logic [15:0] rf_data;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic [15:0] ea;
  logic        done;
  logic        illegal;
  logic        busy;

  logic [15:0] regs [16];
  int n_checks = 0;
  int n_fail = 0;
  int lat = 0;
  int cnt = 0;
  bit pend = 0;

  always #2 clk = ~clk;

  eag_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .reg_sel(reg_sel),
    .pc(pc), .ilen(ilen), .field(field), .rf_addr(rf_addr), .rf_data(rf_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata), .ea(ea), .done(done), .illegal(illegal), .busy(busy)
  );

  assign rf_data = regs[rf_addr];

  function automatic logic [15:0] mem_fn(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] exp_rel(input logic [15:0] p, input logic [1:0] n, input logic [15:0] f);
    int d;
    d = f[7] ? int'(f[7:0]) - 256 : int'(f[7:0]);
    return 16'((int'(p) + int'(n) + d) & 32'hFFFF);
  endfunction

  function automatic logic [15:0] exp_reg(input logic [15:0] r, input logic [15:0] f);
    int s;
    s = f[15] ? int'(f) - 65536 : int'(f);
    return 16'((int'(r) + s) & 32'hFFFF);
  endfunction

  // memory model: answers one request after lat idle cycles
  always @(posedge clk) begin
    if (mem_valid) mem_valid <= 1'b0;
    else if (mem_req && !pend) begin
      pend <= 1'b1;
      cnt  <= lat;
    end else if (pend) begin
      if (cnt == 0) begin
        mem_valid <= 1'b1;
        mem_rdata <= mem_fn(mem_addr);
        pend      <= 1'b0;
      end else cnt <= cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] m, input logic [3:0] s, input logic [15:0] p,
                        input logic [1:0] l, input logic [15:0] f, input int lt);
    logic [15:0] prev;
    logic [15:0] exp;
    logic [15:0] addr;
    prev = ea;
    lat  = lt;
    @(negedge clk);
    start = 1'b1; mode = m; reg_sel = s; pc = p; ilen = l; field = f;
    @(negedge clk);
    start = 1'b0;
    if (m == 3'b000 || m == 3'b001 || m == 3'b010) begin
      exp = (m == 3'b000) ? exp_rel(p, l, f) : exp_reg(regs[s], f);
      if (m == 3'b000) chk(done && ea == exp, "R1", ea, exp);
      else if (m == 3'b001) chk(done && ea == exp, "R2", ea, exp);
      else chk(done && ea == exp, "R3", ea, exp);
      chk(!mem_req && !illegal, "R6", {15'b0, mem_req}, 16'h0);
      @(negedge clk);
      chk(!done, "R6", {15'b0, done}, 16'h0);
    end else if (m == 3'b011 || m == 3'b100) begin
      addr = (m == 3'b011) ? exp_reg(regs[s], f) : f;
      chk(mem_req && mem_addr == addr, (m == 3'b011) ? "R4" : "R5", mem_addr, addr);
      chk(!done, "R6", {15'b0, done}, 16'h0);
      for (int k = 0; k < 20 && !done; k++) begin
        @(negedge clk);
        if (!done) chk(mem_req && mem_addr == addr, "R8", mem_addr, addr);
      end
      exp = mem_fn(addr);
      chk(done && ea == exp, (m == 3'b011) ? "R4" : "R5", ea, exp);
      chk(!mem_req, "R8", {15'b0, mem_req}, 16'h0);
      @(negedge clk);
      chk(!done, "R6", {15'b0, done}, 16'h0);
    end else begin
      chk(illegal && !done && !mem_req && ea == prev, "R7", ea, prev);
      @(negedge clk);
      chk(!illegal && !done, "R7", {15'b0, illegal}, 16'h0);
    end
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] keep;
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) regs[i] = 16'h1111 * i[15:0] + 16'h0203;
    regs[3] = 16'hFFF0;
    regs[5] = 16'h1000;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(ea == 16'h0 && !done && !illegal && !mem_req && !busy, "R10", ea, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ea == 16'h0 && !done && !busy, "R10", ea, 16'h0);

    // R1 directed: forward, backward, wrap
    run_op(3'b000, 4'd0, 16'h2000, 2'd2, 16'h0006, 0);
    chk(ea == 16'h2008, "R1", ea, 16'h2008);
    run_op(3'b000, 4'd0, 16'h0010, 2'd2, 16'h00F0, 0);
    chk(ea == 16'h0002, "R1", ea, 16'h0002);
    run_op(3'b000, 4'd0, 16'hFFFE, 2'd3, 16'h007F, 0);
    // R2 / R3 directed, including wrap and negative offsets
    run_op(3'b001, 4'd5, 16'h0, 2'd0, 16'h0234, 0);
    run_op(3'b010, 4'd3, 16'h0, 2'd0, 16'h0020, 0);
    run_op(3'b010, 4'd5, 16'h0, 2'd0, 16'h8000, 0);
    run_op(3'b010, 4'd5, 16'h0, 2'd0, 16'h7FFF, 0);
    // R4 / R5 directed with several latencies
    run_op(3'b011, 4'd5, 16'h0, 2'd0, 16'h0234, 0);
    run_op(3'b011, 4'd3, 16'h0, 2'd0, 16'h0020, 3);
    run_op(3'b100, 4'd5, 16'h0, 2'd0, 16'h4321, 2);
    // R7 all unknown codes
    run_op(3'b101, 4'd1, 16'h0, 2'd0, 16'h1111, 0);
    run_op(3'b110, 4'd1, 16'h0, 2'd0, 16'h2222, 0);
    run_op(3'b111, 4'd1, 16'h0, 2'd0, 16'h3333, 0);

    // R9 start while busy is ignored
    lat = 3;
    @(negedge clk);
    start = 1'b1; mode = 3'b100; field = 16'h0ABC;
    @(negedge clk);
    mode = 3'b001; reg_sel = 4'd2; field = 16'h0001;
    chk(busy && mem_addr == 16'h0ABC, "R9", mem_addr, 16'h0ABC);
    @(negedge clk);
    start = 1'b0;
    chk(!done && !illegal && mem_addr == 16'h0ABC, "R9", mem_addr, 16'h0ABC);
    for (int k = 0; k < 20 && !done; k++) @(negedge clk);
    keep = mem_fn(16'h0ABC);
    chk(done && ea == keep, "R9", ea, keep);
    @(negedge clk);
    chk(!done && !busy, "R9", {15'b0, done}, 16'h0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      run_op(3'($urandom_range(7)), 4'($urandom_range(15)), 16'($urandom),
             2'($urandom_range(3)), 16'($urandom), int'($urandom_range(3)));
      if (i % 50 == 0) regs[$urandom_range(15)] = 16'($urandom);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule